// File: doc/BRIEF.md
# Low-Address Relocation and Page Usage Tracker

This block sits after address translation. Each cycle it may receive one real page address together with flags that say whether the access may read and whether it may write. Real addresses below a fixed low boundary are moved into a per-CPU window by adding a relocation base. Addresses at or above that boundary keep their value. The resulting absolute address is compared with the top of installed memory. An address past that top is reported as an addressing fault instead of completing.

For every access that lands inside installed memory, the block records usage in a per-page key held in internal registers. A permitted read sets the page's referenced bit. A permitted write sets its modified bit. Software can read any key through a combinational port and can overwrite a key through a write strobe, which is how the usage bits are cleared. The access-control and fetch-control fields of the key are stored, but they have no effect inside this block.

Top module: `pfx_key_tracker`

## Requirements
- R1: While reset is asserted and right after it, `res_valid` and `res_fault` are 0 and every page key reads 0.
- R2: When an access presents an address below `LOW_BOUND` (0x2000), `res_addr` on the following cycle equals `acc_addr + prefix_base`, taken modulo 2^ADDR_W.
- R3: When an access presents an address at or above `LOW_BOUND`, `res_addr` on the following cycle equals `acc_addr`.
- R4: `res_fault` is 1 on the cycle after an access exactly when the absolute address is greater than `mem_top`. A fault is only ever flagged together with `res_valid`.
- R5: A non-faulting access with `acc_rd`=1 sets bit 1 (referenced) of the key for page `absolute >> 12`.
- R6: A non-faulting access with `acc_wr`=1 sets bit 0 (modified) of the key for page `absolute >> 12`.
- R7: A faulting access changes no key. An access whose page number is not below `NUM_PAGES` also changes no key.
- R8: An access never clears any key bit. It leaves keys of other pages untouched. An access with neither flag set changes no key.
- R9: With `key_we`=1, the 7-bit `key_wdata` replaces the key of page `key_idx`. Bits [6:2] are stored and returned unchanged. If an access hits the same page in the same cycle, its bits are ORed on top of the written value.
- R10: `key_rdata` shows the key of page `key_idx` combinationally. A key change caused at a clock edge is visible immediately after that edge.
- R11: `res_valid` is 1 on a cycle exactly when `acc_valid` was 1 on the cycle before. Without `acc_valid`, no key changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_rd | input | 1 | The access is read-permitted |
| acc_wr | input | 1 | The access is write-permitted |
| acc_addr | input | ADDR_W | Real page address |
| prefix_base | input | ADDR_W | Relocation base added to low addresses |
| mem_top | input | ADDR_W | Highest valid absolute address |
| res_valid | output | 1 | Result of the previous cycle's access |
| res_addr | output | ADDR_W | Absolute address of that access |
| res_fault | output | 1 | The absolute address lies beyond `mem_top` |
| key_idx | input | IDX_W | Page selected for key read and write |
| key_we | input | 1 | Overwrite the selected key |
| key_wdata | input | 7 | New key value |
| key_rdata | output | 7 | Current key of the selected page |

## Verification
The bench builds the block with a 16-bit address and 16 pages of 4 KiB. With those values the page array covers the whole address space, and relocation sums wrap at 64 KiB. It can therefore sweep both edges of every page under several relocation bases and memory tops, including bases that push low addresses past the wrap point and tops that cut memory in the middle of a page. After every access, all 16 keys are read back and compared with a model built from the read and write flags, so any stray set, clear or page mix-up shows at the port. Collisions between a software write and an access to the same page are driven explicitly.

// File: rtl/pfx_key_pkg.sv
package pfx_key_pkg;
  localparam int KEY_W = 7;

  // Page key layout: [6:3] access control, [2] fetch control, [1] referenced, [0] modified
  typedef struct packed {
    logic [3:0] acc_ctl;
    logic       fetch_ctl;
    logic       ref_bit;
    logic       chg_bit;
  } page_key_t;
endpackage

// File: rtl/pfx_reloc.sv
module pfx_reloc #(
  parameter int          ADDR_W     = 32,
  parameter int unsigned LOW_BOUND  = 32'h2000,
  parameter int          PAGE_SHIFT = 12,
  parameter int          NUM_PAGES  = 64,
  parameter int          IDX_W      = $clog2(NUM_PAGES)
) (
  input  logic [ADDR_W-1:0] real_addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  output logic [ADDR_W-1:0] abs_addr,
  output logic              beyond,
  output logic              page_ok,
  output logic [IDX_W-1:0]  page_idx
);
  localparam logic [ADDR_W-1:0] LOW_V   = ADDR_W'(LOW_BOUND);
  localparam logic [ADDR_W-1:0] PAGES_V = ADDR_W'(NUM_PAGES);

  logic [ADDR_W-1:0] page_num;

  always_comb begin
    if (real_addr < LOW_V) abs_addr = real_addr + base;
    else                   abs_addr = real_addr;
    beyond   = abs_addr > limit;
    page_num = abs_addr >> PAGE_SHIFT;
    page_ok  = !beyond && (page_num < PAGES_V);
    page_idx = page_num[IDX_W-1:0];
  end
endmodule

// File: rtl/pfx_key_array.sv
module pfx_key_array
  import pfx_key_pkg::*;
#(
  parameter int NUM_PAGES = 64,
  parameter int IDX_W     = $clog2(NUM_PAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             set_ref,
  input  logic             set_chg,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  page_key_t        wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output page_key_t        rd_data
);
  page_key_t key_view [NUM_PAGES];

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    page_key_t key_q;
    page_key_t key_d;
    logic      hit_upd;
    logic      hit_wr;
    logic      key_en;

    always_comb begin
      hit_upd = upd_en && (upd_idx == IDX_W'(g));
      hit_wr  = wr_en && (wr_idx == IDX_W'(g));
      key_en  = hit_upd || hit_wr;
      key_d   = hit_wr ? wr_data : key_q;
      if (hit_upd) begin
        key_d.ref_bit = key_d.ref_bit | set_ref;
        key_d.chg_bit = key_d.chg_bit | set_chg;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      key_q <= '0;
      else if (key_en) key_q <= key_d;
    end

    assign key_view[g] = key_q;
  end

  always_comb begin
    if (int'(rd_idx) < NUM_PAGES) rd_data = key_view[rd_idx];
    else                          rd_data = '0;
  end
endmodule

// File: rtl/pfx_key_tracker.sv
module pfx_key_tracker
  import pfx_key_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int unsigned LOW_BOUND  = 32'h2000,
  parameter int          PAGE_SHIFT = 12,
  parameter int          NUM_PAGES  = 64,
  parameter int          IDX_W      = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ADDR_W-1:0] prefix_base,
  input  logic [ADDR_W-1:0] mem_top,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_addr,
  output logic              res_fault,
  input  logic [IDX_W-1:0]  key_idx,
  input  logic              key_we,
  input  logic [KEY_W-1:0]  key_wdata,
  output logic [KEY_W-1:0]  key_rdata
);
  logic [ADDR_W-1:0] abs_addr;
  logic              beyond;
  logic              page_ok;
  logic [IDX_W-1:0]  page_idx;
  page_key_t         rd_key;

  pfx_reloc #(
    .ADDR_W(ADDR_W), .LOW_BOUND(LOW_BOUND), .PAGE_SHIFT(PAGE_SHIFT),
    .NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)
  ) u_reloc (
    .real_addr(acc_addr), .base(prefix_base), .limit(mem_top),
    .abs_addr(abs_addr), .beyond(beyond), .page_ok(page_ok), .page_idx(page_idx)
  );

  pfx_key_array #(.NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)) u_keys (
    .clk(clk), .rst_n(rst_n),
    .upd_en(acc_valid && page_ok), .upd_idx(page_idx),
    .set_ref(acc_rd), .set_chg(acc_wr),
    .wr_en(key_we), .wr_idx(key_idx), .wr_data(page_key_t'(key_wdata)),
    .rd_idx(key_idx), .rd_data(rd_key)
  );

  assign key_rdata = KEY_W'(rd_key);

  logic              valid_d;
  logic              fault_d;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  always_comb begin
    valid_d = acc_valid;
    fault_d = acc_valid && beyond;
    addr_en = acc_valid;
    addr_d  = abs_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_fault <= 1'b0;
    end else begin
      res_valid <= valid_d;
      res_fault <= fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       res_addr <= '0;
    else if (addr_en) res_addr <= addr_d;
  end
endmodule

// File: rtl/pfx_key_tracker_chk.sv
module pfx_key_tracker_chk #(
  parameter int          ADDR_W    = 32,
  parameter int unsigned LOW_BOUND = 32'h2000,
  parameter int          IDX_W     = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [ADDR_W-1:0] prefix_base,
  input logic [ADDR_W-1:0] mem_top,
  input logic              res_valid,
  input logic [ADDR_W-1:0] res_addr,
  input logic              res_fault,
  input logic [IDX_W-1:0]  key_idx,
  input logic              key_we,
  input logic [6:0]        key_rdata
);
  localparam logic [ADDR_W-1:0] LOW_V = ADDR_W'(LOW_BOUND);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r2_low_relocated: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(acc_valid) && ($past(acc_addr) < LOW_V)
    |-> res_addr == ADDR_W'($past(acc_addr) + $past(prefix_base)));

  a_r3_high_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(acc_valid) && ($past(acc_addr) >= LOW_V)
    |-> res_addr == $past(acc_addr));

  a_r4_fault_vs_top: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(acc_valid) |-> res_fault == (res_addr > $past(mem_top)));

  a_r4_fault_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    res_fault |-> res_valid);

  a_r11_idle_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(acc_valid) |-> !res_valid);

  a_r8_bits_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(key_we) && $stable(key_idx)
    |-> (($past(key_rdata) & ~key_rdata) == 7'd0));
endmodule

bind pfx_key_tracker pfx_key_tracker_chk #(
  .ADDR_W(ADDR_W), .LOW_BOUND(LOW_BOUND), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .prefix_base(prefix_base), .mem_top(mem_top), .res_valid(res_valid),
  .res_addr(res_addr), .res_fault(res_fault), .key_idx(key_idx),
  .key_we(key_we), .key_rdata(key_rdata)
);

// File: tb/pfx_key_tracker_test.sv
module pfx_key_tracker_test;
  localparam int AW = 16;
  localparam int NP = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, acc_valid, acc_rd, acc_wr, key_we;
  logic [AW-1:0] acc_addr, prefix_base, mem_top;
  logic          res_valid, res_fault;
  logic [AW-1:0] res_addr;
  logic [IW-1:0] key_idx;
  logic [6:0]    key_wdata, key_rdata;

  pfx_key_tracker #(.ADDR_W(AW), .LOW_BOUND(32'h2000), .PAGE_SHIFT(12),
                    .NUM_PAGES(NP), .IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_rd(acc_rd),
    .acc_wr(acc_wr), .acc_addr(acc_addr), .prefix_base(prefix_base),
    .mem_top(mem_top), .res_valid(res_valid), .res_addr(res_addr),
    .res_fault(res_fault), .key_idx(key_idx), .key_we(key_we),
    .key_wdata(key_wdata), .key_rdata(key_rdata)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [6:0] mkeys [NP];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_keys(input string req);
    for (int i = 0; i < NP; i++) begin
      key_idx = IW'(i);
      #1;
      chk(key_rdata == mkeys[i], req, {25'd0, key_rdata}, {25'd0, mkeys[i]});
    end
  endtask

  task automatic sw_write(input int pg, input logic [6:0] val);
    @(negedge clk);
    key_we = 1'b1; key_idx = IW'(pg); key_wdata = val;
    @(negedge clk);
    key_we = 1'b0;
    mkeys[pg] = val;
  endtask

  task automatic clear_all();
    for (int i = 0; i < NP; i++) sw_write(i, 7'd0);
    check_keys("R9 clear");
  endtask

  task automatic access(input logic [AW-1:0] a, input bit rd, input bit wr);
    logic [AW-1:0] ab;
    bit flt;
    ab  = (a < 16'h2000) ? AW'(a + prefix_base) : a;
    flt = ab > mem_top;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_rd = rd; acc_wr = wr;
    @(negedge clk);
    acc_valid = 1'b0;
    chk(res_valid == 1'b1, "R11 valid", {31'd0, res_valid}, 32'd1);
    if (a < 16'h2000) chk(res_addr == ab, "R2 reloc", {16'd0, res_addr}, {16'd0, ab});
    else              chk(res_addr == ab, "R3 pass", {16'd0, res_addr}, {16'd0, ab});
    chk(res_fault == flt, "R4 fault", {31'd0, res_fault}, {31'd0, flt});
    if (!flt) begin
      if (rd) mkeys[ab[15:12]][1] = 1'b1;
      if (wr) mkeys[ab[15:12]][0] = 1'b1;
    end
    check_keys(flt ? "R7 no update" : "R5 R6 R8 keys");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R11 watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] bases [4];
    logic [AW-1:0] tops [3];
    int n;
    bases[0] = 16'h0000; bases[1] = 16'h3000; bases[2] = 16'hF000; bases[3] = 16'h5800;
    tops[0]  = 16'hFFFF; tops[1]  = 16'h7FFF; tops[2]  = 16'h37FF;
    for (int i = 0; i < NP; i++) mkeys[i] = 7'd0;
    rst_n = 1'b0; acc_valid = 1'b0; acc_rd = 1'b0; acc_wr = 1'b0;
    acc_addr = '0; prefix_base = '0; mem_top = '0;
    key_we = 1'b0; key_idx = '0; key_wdata = '0;
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R1 valid", {31'd0, res_valid}, 32'd0);
    chk(res_fault == 1'b0, "R1 fault", {31'd0, res_fault}, 32'd0);
    check_keys("R1 keys");
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b0, "R11 idle", {31'd0, res_valid}, 32'd0);
    check_keys("R1 after release");

    n = 0;
    for (int b = 0; b < 4; b++) begin
      for (int t = 0; t < 3; t++) begin
        prefix_base = bases[b];
        mem_top = tops[t];
        clear_all();
        for (int p = 0; p < NP; p++) begin
          access(AW'(p * 4096), n[0], n[1]); n++;
          access(AW'(p * 4096 + 4095), n[0], n[1]); n++;
        end
        access(16'h1FFF, 1'b1, 1'b1);
        access(16'h2000, 1'b1, 1'b0);
        @(negedge clk);
        chk(res_valid == 1'b0, "R11 no access", {31'd0, res_valid}, 32'd0);
        check_keys("R11 keys idle");
      end
    end

    prefix_base = 16'h0000; mem_top = 16'hFFFF;
    clear_all();
    sw_write(3, 7'h7C);
    check_keys("R9 R10 full key");
    access(16'h3000, 1'b1, 1'b0);
    chk(mkeys[3] == 7'h7E, "R9 model", {25'd0, mkeys[3]}, 32'h7E);
    access(16'h3100, 1'b0, 1'b0);

    @(negedge clk);
    key_we = 1'b1; key_idx = 4'd5; key_wdata = 7'h40;
    acc_valid = 1'b1; acc_addr = 16'h5000; acc_rd = 1'b0; acc_wr = 1'b1;
    @(negedge clk);
    key_we = 1'b0; acc_valid = 1'b0;
    mkeys[5] = 7'h41;
    check_keys("R9 collision");

    access(16'h6000, 1'b1, 1'b1);
    sw_write(6, 7'h02);
    check_keys("R9 R10 clear modified only");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule